// File: doc/BRIEF.md
# Triple-Redundant Accumulator with Stall, Repair and Input Replay

This block wraps three identical accumulating datapath replicas and votes bit by bit on their state. While all three agree, each accepted input sample is added to every replica, and the voted state is driven out. When one replica disagrees with the other two, the wrapper marks it as faulty and stops all three replicas. It keeps accepting input samples into a FIFO so that nothing the sender offers is lost, and it waits for an external repair-done pulse. That pulse stands in for the reconfiguration of the faulty replica.

After the pulse, the wrapper spends one cycle writing a healthy replica's state into the repaired one. It then feeds the buffered samples, oldest first, to all three replicas. Samples that arrive during this drain join the tail of the FIFO. Live operation resumes once the FIFO is empty. If all three replicas disagree, no majority exists, so the wrapper raises an unrecoverable flag and stays stopped until reset.

A fault-injection input lets a test upset a replica on purpose. Replica k inverts bit k of its state on the edge where its bit of that input is high.

Top module: `tmr_replay_wrap`

## Requirements
- R1: In live operation, every accepted sample (in_valid and in_ready both high at an edge) is added modulo 2^W to the state. out_data shows the new majority state after that edge. When in_valid is low, out_data does not change.
- R2: When exactly one replica differs from the other two, halted rises after the next edge and faulty_idx shows that replica's index (0, 1 or 2). From then on, out_data stays constant until the repair-done pulse.
- R3: While halted, accepted samples are stored in the FIFO and in_ready stays high until DEPTH samples are held. After that, in_ready is low. An offered sample (in_valid high) while in_ready is low sets overflow after the edge. The sample that arrives in the cycle the disagreement is first seen is also stored.
- R4: Without a repair-done pulse the wrapper stays halted, with out_data constant, for any number of cycles.
- R5: A repair-done pulse while halted starts a one-cycle state copy and then the drain. When halted falls again, out_data equals the modulo-2^W sum of every sample accepted since reset, and overflow is 0.
- R6: Samples accepted during the drain are appended behind the backlog and are included in the final sum.
- R7: When all three replicas differ, in_ready is 0 at once and unrecoverable and halted are 1 after the next edge. All three stay that way even if a repair-done pulse arrives.
- R8: After reset, in_ready is 1, halted, overflow and unrecoverable are 0, and out_data is 0.
- R9: After a recovery, the repaired replica holds the healthy state. A later upset of a different replica is then reported with that replica's own index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_data | input | W | Input sample value |
| in_ready | output | 1 | Sample accepted at the edge when in_valid is also high |
| fault_flip | input | 3 | Bit k inverts bit k of replica k at the edge |
| repair_done | input | 1 | Pulse: faulty replica has been reconfigured |
| out_data | output | W | Bitwise majority of the replica states |
| halted | output | 1 | Wrapper is not in live operation |
| faulty_idx | output | 2 | Index of the replica found faulty |
| unrecoverable | output | 1 | All three replicas disagreed |
| overflow | output | 1 | Sample offered while the FIFO was full; cleared on return to live operation |

## Verification
The assertions assume that the sender holds off while in_ready is low. They also assume that fault_flip is used only in live operation, and that repair_done is pulsed only while the wrapper waits for repair. The bench offers samples only after reading in_ready for that cycle, and it counts a sample as accepted only when in_ready was high. It raises fault_flip only in live cycles and pulses repair_done only after halted has been seen high. Fault patterns upset a single replica, or two replicas on different bits, which are the only two disagreement shapes the voter must handle.

// File: rtl/tmr_pkg.sv
// Shared types for the redundant accumulator wrapper.
// Assumes: nothing beyond the parameters used by the modules.
package tmr_pkg;
    typedef enum logic [2:0] {
        ST_LIVE     = 3'd0,
        ST_WAIT_FIX = 3'd1,
        ST_ROLL     = 3'd2,
        ST_DRAIN    = 3'd3,
        ST_DEAD     = 3'd4
    } sync_state_e;
endpackage

// File: rtl/acc_replica.sv
// One accumulator replica: adds a sample when stepped, can be overwritten
// with a state from another replica, and can be upset for tests.
// Assumes: load and step are never both requested in the same cycle.
module acc_replica #(
    parameter int W   = 16,
    parameter int IDX = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic [W-1:0] step_data,
    input  logic         load_en,
    input  logic [W-1:0] load_data,
    input  logic         flip,
    output logic [W-1:0] state_q
);
    localparam logic [W-1:0] FLIP_MASK = W'(1) << IDX;

    logic [W-1:0] advanced;

    // Next value when no load is requested: optional add, optional upset.
    always_comb begin
        advanced = step_en ? state_q + step_data : state_q;
        if (flip) advanced = advanced ^ FLIP_MASK;
    end

    // State register: a load takes priority over stepping.
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= '0;
        else if (load_en) state_q <= load_data;
        else              state_q <= advanced;
    end

    // R5: a load and a step in the same cycle would lose a sample.
    p_load_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> !step_en);
endmodule

// File: rtl/maj_voter.sv
// Bitwise majority of three words, with a classification of the disagreement.
// Assumes: the inputs are registered replica states.
module maj_voter #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] maj,
    output logic         agree,
    output logic         split,
    output logic [1:0]   odd_idx
);
    logic eq_ab, eq_bc, eq_ac;

    // Majority word and pairwise equality.
    always_comb begin
        maj   = (a & b) | (b & c) | (a & c);
        eq_ab = (a == b);
        eq_bc = (b == c);
        eq_ac = (a == c);
        agree = eq_ab && eq_bc;
        split = !eq_ab && !eq_bc && !eq_ac;
    end

    // Index of the single replica that differs from the other two.
    always_comb begin
        if (!eq_ab && eq_bc)      odd_idx = 2'd0;
        else if (!eq_ab && eq_ac) odd_idx = 2'd1;
        else if (eq_ab && !eq_bc) odd_idx = 2'd2;
        else                      odd_idx = 2'd0;
    end
endmodule

// File: rtl/sample_fifo.sv
// Circular FIFO that holds input samples while the replicas are stopped.
// Assumes: the caller pushes only when not full and pops only when not empty.
module sample_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    // Sample storage.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Pointers and fill level, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // R3: the wrapper must hold the sender off before the FIFO overruns.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R5: the drain never reads an empty FIFO.
    p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/tmr_replay_wrap.sv
// Triple-redundant accumulator wrapper. It stops the replicas on a
// disagreement and buffers inputs. After the repair-done pulse it copies a
// healthy state into the repaired replica and replays the backlog to all three.
// Assumes: fault_flip is used only in live operation; repair_done is a pulse.
module tmr_replay_wrap
    import tmr_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    input  logic [2:0]   fault_flip,
    input  logic         repair_done,
    output logic [W-1:0] out_data,
    output logic         halted,
    output logic [1:0]   faulty_idx,
    output logic         unrecoverable,
    output logic         overflow
);
    localparam int NREP = 3;

    sync_state_e  st_q, st_d;
    logic [W-1:0] rep_state [NREP];
    logic [1:0]   bad_q;
    logic         agree, split;
    logic [1:0]   odd_idx;
    logic         fifo_push, fifo_pop, fifo_full, fifo_empty;
    logic [W-1:0] fifo_head;
    logic         step_en;
    logic [W-1:0] step_data;
    logic [W-1:0] heal_data;
    logic         ovf_q;

    // Three replicas; only the faulty one is loaded during the copy cycle.
    for (genvar k = 0; k < NREP; k++) begin : g_rep
        acc_replica #(.W(W), .IDX(k)) u_rep (
            .clk       (clk),
            .rst_n     (rst_n),
            .step_en   (step_en),
            .step_data (step_data),
            .load_en   ((st_q == ST_ROLL) && (bad_q == 2'(k))),
            .load_data (heal_data),
            .flip      (fault_flip[k]),
            .state_q   (rep_state[k])
        );
    end

    maj_voter #(.W(W)) u_vote (
        .a       (rep_state[0]),
        .b       (rep_state[1]),
        .c       (rep_state[2]),
        .maj     (out_data),
        .agree   (agree),
        .split   (split),
        .odd_idx (odd_idx)
    );

    sample_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (in_data),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    // Source of the healthy state: any replica other than the faulty one.
    assign heal_data = (bad_q == 2'd0) ? rep_state[1] : rep_state[0];

    // Input acceptance, replica stepping and FIFO control per state.
    always_comb begin
        in_ready  = 1'b0;
        step_en   = 1'b0;
        step_data = in_data;
        fifo_push = 1'b0;
        fifo_pop  = 1'b0;
        unique case (st_q)
            ST_LIVE: begin
                in_ready  = !split;
                step_en   = in_valid && agree;
                fifo_push = in_valid && !agree && !split;
            end
            ST_WAIT_FIX, ST_ROLL: begin
                in_ready  = !fifo_full;
                fifo_push = in_valid && !fifo_full;
            end
            ST_DRAIN: begin
                in_ready = !fifo_full;
                if (!fifo_empty) begin
                    step_en   = 1'b1;
                    step_data = fifo_head;
                    fifo_pop  = 1'b1;
                    fifo_push = in_valid && !fifo_full;
                end else begin
                    step_en   = in_valid;
                end
            end
            default: ;
        endcase
    end

    // Next-state logic of the recovery sequence.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LIVE:     if (split) st_d = ST_DEAD;
                         else if (!agree) st_d = ST_WAIT_FIX;
            ST_WAIT_FIX: if (repair_done) st_d = ST_ROLL;
            ST_ROLL:     st_d = ST_DRAIN;
            ST_DRAIN:    if (fifo_empty) st_d = ST_LIVE;
            default:     st_d = ST_DEAD;
        endcase
    end

    // State register and the index of the faulty replica, latched on detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_LIVE;
            bad_q <= 2'd0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_LIVE && !agree && !split) bad_q <= odd_idx;
        end
    end

    // Overflow flag: set when a sample is refused, cleared on return to live.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     ovf_q <= 1'b0;
        else if (st_d == ST_LIVE)                       ovf_q <= 1'b0;
        else if (st_q != ST_DEAD && in_valid && !in_ready) ovf_q <= 1'b1;
    end

    assign halted        = (st_q != ST_LIVE);
    assign faulty_idx    = bad_q;
    assign unrecoverable = (st_q == ST_DEAD);
    assign overflow      = ovf_q;

    // R2/R4: the voted state does not move while waiting for repair.
    p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_FIX) |=> $stable(out_data));
    // R9: after the copy cycle all three replicas hold the same state.
    p_copy_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ROLL) |=> agree);
    // R7: once unrecoverable, it stays so and accepts nothing.
    p_dead_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        unrecoverable |=> (unrecoverable && !in_ready));
    // R3: a full FIFO outside live operation refuses input.
    p_ready_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && fifo_full) |-> !in_ready);
endmodule

// File: tb/test_tmr_replay_wrap.sv
module test_tmr_replay_wrap;
    localparam int W     = 16;
    localparam int DEPTH = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic [2:0]   fault_flip = 3'b000;
    logic         repair_done = 1'b0;
    logic         in_ready, halted, unrecoverable, overflow;
    logic [W-1:0] out_data;
    logic [1:0]   faulty_idx;

    int           n_chk = 0;
    int           n_bad = 0;
    logic [W-1:0] exp_sum = '0;
    logic         last_acc;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    tmr_replay_wrap #(.W(W), .DEPTH(DEPTH)) i_tmr_replay_wrap (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .fault_flip(fault_flip), .repair_done(repair_done),
        .out_data(out_data), .halted(halted), .faulty_idx(faulty_idx),
        .unrecoverable(unrecoverable), .overflow(overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle from a falling edge; return at the next falling edge.
    task automatic tick(input logic v, input logic [W-1:0] d, input logic [2:0] fl);
        in_valid   = v;
        in_data    = d;
        fault_flip = fl;
        #1;
        last_acc = v && in_ready;
        if (last_acc) exp_sum = exp_sum + d;
        @(negedge clk);
        in_valid    = 1'b0;
        fault_flip  = 3'b000;
        repair_done = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        exp_sum = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R8 in_ready", in_ready, 1);
        chk("R8 halted", halted, 0);
        chk("R8 overflow", overflow, 0);
        chk("R8 unrecoverable", unrecoverable, 0);
        chk("R8 out_data", out_data, 0);
    endtask

    task automatic t_live();
        logic [W-1:0] vals [5] = '{16'h0003, 16'h0100, 16'hFFF0, 16'h0021, 16'h7000};
        foreach (vals[i]) begin
            tick(1'b1, vals[i], 3'b000);
            chk("R1 sum", out_data, exp_sum);
        end
        tick(1'b0, 16'h1234, 3'b000);
        chk("R1 idle hold", out_data, exp_sum);
    endtask

    // Upset one replica, then fill the FIFO and overrun it (R2, R3, R4).
    task automatic t_fault_fill(input int idx);
        logic [W-1:0] frozen;
        int           pushed;
        tick(1'b1, 16'h0011, 3'(1 << idx));
        chk("R2 voted state unaffected", out_data, exp_sum);
        frozen = out_data;
        pushed = 0;
        for (int i = 0; i < DEPTH + 4; i++) begin
            tick(1'b1, W'(16'h0040 + i), 3'b000);
            if (last_acc) pushed++;
            else break;
        end
        chk("R2 halted", halted, 1);
        chk("R2 faulty_idx", faulty_idx, idx);
        chk("R3 buffered count", pushed, DEPTH);
        chk("R3 overflow on refused sample", overflow, 1);
        chk("R3 ready low when full", in_ready, 0);
        for (int i = 0; i < 20; i++) tick(1'b0, '0, 3'b000);
        chk("R4 still halted", halted, 1);
        chk("R4 out frozen", out_data, frozen);
    endtask

    // Repair, feed more samples during the drain, wait for live (R5, R6).
    task automatic t_repair(input string tag);
        int extra;
        int guard;
        repair_done = 1'b1;
        tick(1'b0, '0, 3'b000);
        extra = 0;
        guard = 0;
        while (extra < 3 && guard < 10) begin
            tick(1'b1, W'(16'h0500 + extra), 3'b000);
            if (last_acc) extra++;
            guard++;
        end
        chk("R6 drain accepted samples", extra, 3);
        guard = 0;
        while (halted && guard < 40) begin
            tick(1'b0, '0, 3'b000);
            guard++;
        end
        chk({"R5 back to live ", tag}, halted, 0);
        chk({"R5 R6 replayed sum ", tag}, out_data, exp_sum);
        chk("R5 overflow cleared", overflow, 0);
        tick(1'b1, 16'h0009, 3'b000);
        chk("R5 live after repair", out_data, exp_sum);
    endtask

    task automatic t_second_fault();
        tick(1'b1, 16'h0002, 3'b010);
        tick(1'b0, '0, 3'b000);
        chk("R9 halted on second fault", halted, 1);
        chk("R9 faulty_idx of new replica", faulty_idx, 1);
        chk("R9 voted state intact", out_data, exp_sum);
        t_repair("second");
    endtask

    task automatic t_dead();
        do_reset();
        tick(1'b1, 16'h0030, 3'b000);
        tick(1'b0, '0, 3'b011);
        chk("R7 ready drops at once", in_ready, 0);
        tick(1'b1, 16'h0001, 3'b000);
        chk("R7 unrecoverable", unrecoverable, 1);
        chk("R7 halted", halted, 1);
        repair_done = 1'b1;
        tick(1'b0, '0, 3'b000);
        for (int i = 0; i < 5; i++) tick(1'b0, '0, 3'b000);
        chk("R7 still unrecoverable", unrecoverable, 1);
        chk("R7 still refusing", in_ready, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_live();
        t_fault_fill(0);
        t_repair("first");
        t_second_fault();
        t_dead();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule